// File: doc/BRIEF.md
# Dual-Port Memory with Mailbox Interrupts

This block is a two-port byte-wide memory with a mailbox interrupt for each port. The two highest addresses are reserved as mailboxes. The second-highest location belongs to the left port and the highest to the right port. When one port writes the other port's mailbox, the owner of that mailbox sees its active-low interrupt asserted. The owner takes the interrupt down by reading its own mailbox. The message byte is ordinary memory content, so the reader gets the byte the sender left.

Both ports are synchronous to one clock. Each port has active-low controls:

- chip enable
- write strobe, where low means write and high means read
- output enable

A port writes when chip enable and the write strobe are both low. A port reads when chip enable and output enable are both low. Read data is registered and holds between reads.

The parameter `MBOX_EN` sets whether the mailbox function exists. With it at zero, the two top locations are plain storage and no interrupt is ever raised. Interrupt outputs are registered and change on the clock edge that samples the access.

Top module: `dpm_mailbox_irq`

## Requirements
- R1: While reset is applied, `l_int_no` and `r_int_no` are high (inactive), and both read-data outputs are 0.
- R2: A port writes `wdata` to `addr` when chip enable is low and the write strobe is low. A port reads when chip enable and output enable are both low. The read returns the stored byte on its `rdata` output one edge later. A read and a write of the same location in the same cycle return the old byte.
- R3: A right-port write to address 2^ADDR_W-2 (the left mailbox) drives `l_int_no` low after the next edge. It stays low until it is cleared.
- R4: A left-port write to address 2^ADDR_W-1 (the right mailbox) drives `r_int_no` low after the next edge. It stays low until it is cleared.
- R5: A left-port access to the left mailbox with chip enable and output enable low drives `l_int_no` high after the next edge. The level of the write strobe does not matter for this clear.
- R6: A right-port access to the right mailbox with chip enable and output enable low drives `r_int_no` high after the next edge.
- R7: When a set and a clear of the same interrupt fall in one cycle, the interrupt is asserted after the edge.
- R8: A port writing its own mailbox does not raise its own interrupt. A mailbox read with chip enable high does not clear the interrupt.
- R9: With `MBOX_EN` = 0, both interrupt outputs stay high at all times. The two top locations store and return data like any other address.
- R10: Mailbox bytes read back as written, and reading a mailbox does not alter its content.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| l_ce_ni | input | 1 | Left chip enable, active low |
| l_we_ni | input | 1 | Left write strobe (low = write) |
| l_oe_ni | input | 1 | Left output enable, active low |
| l_addr_i | input | ADDR_W | Left address |
| l_wdata_i | input | DATA_W | Left write data |
| l_rdata_o | output | DATA_W | Left registered read data |
| l_int_no | output | 1 | Left mailbox interrupt, active low |
| r_ce_ni | input | 1 | Right chip enable, active low |
| r_we_ni | input | 1 | Right write strobe (low = write) |
| r_oe_ni | input | 1 | Right output enable, active low |
| r_addr_i | input | ADDR_W | Right address |
| r_wdata_i | input | DATA_W | Right write data |
| r_rdata_o | output | DATA_W | Right registered read data |
| r_int_no | output | 1 | Right mailbox interrupt, active low |

## Verification
The interrupt properties assume that every control and address input is settled at each sampling edge. They also assume that software never has both ports write one address in the same cycle. The bench changes inputs only on the falling edge, and it never issues two writes to one location in the same cycle. The set-against-clear collision is still applied on purpose, and read-with-write on one location is covered too. A second instance with the mailbox function disabled receives the same stimulus as the main one.

// File: rtl/dpm_pkg.sv
package dpm_pkg;
  typedef enum logic {PORT_L = 1'b0, PORT_R = 1'b1} port_e;

  // mailbox of a port: left at top-1, right at top
  function automatic int unsigned mbox_idx(int unsigned aw, port_e p);
    return (32'd1 << aw) - 32'd2 + {31'd0, p};
  endfunction
endpackage

// File: rtl/dpm_port_dec.sv
module dpm_port_dec #(
  parameter int unsigned ADDR_W  = 10,
  parameter bit          MBOX_EN = 1'b1,
  parameter int unsigned OWN_MB  = 0,
  parameter int unsigned PEER_MB = 1
) (
  input  logic              ce_ni,
  input  logic              we_ni,
  input  logic              oe_ni,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              wr_o,
  output logic              rd_o,
  output logic              set_peer_o,
  output logic              clr_own_o
);
  localparam logic [ADDR_W-1:0] OwnA  = ADDR_W'(OWN_MB);
  localparam logic [ADDR_W-1:0] PeerA = ADDR_W'(PEER_MB);

  assign wr_o = !ce_ni && !we_ni;
  assign rd_o = !ce_ni && !oe_ni;

  generate
    if (MBOX_EN) begin : g_mbox
      assign set_peer_o = wr_o && (addr_i == PeerA);
      // write strobe level is irrelevant for the clear
      assign clr_own_o  = rd_o && (addr_i == OwnA);
    end else begin : g_plain
      assign set_peer_o = 1'b0;
      assign clr_own_o  = 1'b0;
    end
  endgenerate
endmodule

// File: rtl/dpm_irq_flag.sv
module dpm_irq_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic int_no
);
  logic pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      pend_q <= 1'b0;
    else if (set_i)   pend_q <= 1'b1;  // set wins, message never lost
    else if (clr_i)   pend_q <= 1'b0;
  end

  assign int_no = ~pend_q;
endmodule

// File: rtl/dpm_mem.sv
module dpm_mem #(
  parameter int unsigned ADDR_W = 10,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              l_wr_i,
  input  logic              l_rd_i,
  input  logic [ADDR_W-1:0] l_addr_i,
  input  logic [DATA_W-1:0] l_wdata_i,
  output logic [DATA_W-1:0] l_rdata_o,
  input  logic              r_wr_i,
  input  logic              r_rd_i,
  input  logic [ADDR_W-1:0] r_addr_i,
  input  logic [DATA_W-1:0] r_wdata_i,
  output logic [DATA_W-1:0] r_rdata_o
);
  localparam int unsigned Depth = 1 << ADDR_W;

  logic [DATA_W-1:0] mem_q [Depth];

  always_ff @(posedge clk_i) begin
    if (l_wr_i) mem_q[l_addr_i] <= l_wdata_i;
    if (r_wr_i) mem_q[r_addr_i] <= r_wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      l_rdata_o <= '0;
      r_rdata_o <= '0;
    end else begin
      if (l_rd_i) l_rdata_o <= mem_q[l_addr_i];
      if (r_rd_i) r_rdata_o <= mem_q[r_addr_i];
    end
  end
endmodule

// File: rtl/dpm_mailbox_irq.sv
module dpm_mailbox_irq
  import dpm_pkg::*;
#(
  parameter int unsigned ADDR_W  = 10,
  parameter int unsigned DATA_W  = 8,
  parameter bit          MBOX_EN = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              l_ce_ni,
  input  logic              l_we_ni,
  input  logic              l_oe_ni,
  input  logic [ADDR_W-1:0] l_addr_i,
  input  logic [DATA_W-1:0] l_wdata_i,
  output logic [DATA_W-1:0] l_rdata_o,
  output logic              l_int_no,
  input  logic              r_ce_ni,
  input  logic              r_we_ni,
  input  logic              r_oe_ni,
  input  logic [ADDR_W-1:0] r_addr_i,
  input  logic [DATA_W-1:0] r_wdata_i,
  output logic [DATA_W-1:0] r_rdata_o,
  output logic              r_int_no
);
  localparam int unsigned LMb = mbox_idx(ADDR_W, PORT_L);
  localparam int unsigned RMb = mbox_idx(ADDR_W, PORT_R);

  logic l_wr, l_rd, l_set_r, l_clr_l;
  logic r_wr, r_rd, r_set_l, r_clr_r;

  dpm_port_dec #(
    .ADDR_W(ADDR_W), .MBOX_EN(MBOX_EN), .OWN_MB(LMb), .PEER_MB(RMb)
  ) u_dec_l (
    .ce_ni(l_ce_ni), .we_ni(l_we_ni), .oe_ni(l_oe_ni), .addr_i(l_addr_i),
    .wr_o(l_wr), .rd_o(l_rd), .set_peer_o(l_set_r), .clr_own_o(l_clr_l)
  );

  dpm_port_dec #(
    .ADDR_W(ADDR_W), .MBOX_EN(MBOX_EN), .OWN_MB(RMb), .PEER_MB(LMb)
  ) u_dec_r (
    .ce_ni(r_ce_ni), .we_ni(r_we_ni), .oe_ni(r_oe_ni), .addr_i(r_addr_i),
    .wr_o(r_wr), .rd_o(r_rd), .set_peer_o(r_set_l), .clr_own_o(r_clr_r)
  );

  dpm_irq_flag u_irq_l (
    .clk_i(clk_i), .rst_ni(rst_ni), .set_i(r_set_l), .clr_i(l_clr_l),
    .int_no(l_int_no)
  );

  dpm_irq_flag u_irq_r (
    .clk_i(clk_i), .rst_ni(rst_ni), .set_i(l_set_r), .clr_i(r_clr_r),
    .int_no(r_int_no)
  );

  dpm_mem #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mem (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .l_wr_i(l_wr), .l_rd_i(l_rd), .l_addr_i(l_addr_i),
    .l_wdata_i(l_wdata_i), .l_rdata_o(l_rdata_o),
    .r_wr_i(r_wr), .r_rd_i(r_rd), .r_addr_i(r_addr_i),
    .r_wdata_i(r_wdata_i), .r_rdata_o(r_rdata_o)
  );
endmodule

// File: rtl/dpm_mailbox_chk.sv
module dpm_mailbox_chk #(
  parameter int unsigned ADDR_W  = 10,
  parameter bit          MBOX_EN = 1'b1
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              l_ce_ni,
  input logic              l_we_ni,
  input logic              l_oe_ni,
  input logic [ADDR_W-1:0] l_addr_i,
  input logic              l_int_no,
  input logic              r_ce_ni,
  input logic              r_we_ni,
  input logic              r_oe_ni,
  input logic [ADDR_W-1:0] r_addr_i,
  input logic              r_int_no
);
  localparam logic [ADDR_W-1:0] LMb = ADDR_W'(dpm_pkg::mbox_idx(ADDR_W, dpm_pkg::PORT_L));
  localparam logic [ADDR_W-1:0] RMb = ADDR_W'(dpm_pkg::mbox_idx(ADDR_W, dpm_pkg::PORT_R));

  logic set_l, set_r, clr_l, clr_r;
  assign set_l = MBOX_EN && !r_ce_ni && !r_we_ni && (r_addr_i == LMb);
  assign set_r = MBOX_EN && !l_ce_ni && !l_we_ni && (l_addr_i == RMb);
  assign clr_l = MBOX_EN && !l_ce_ni && !l_oe_ni && (l_addr_i == LMb);
  assign clr_r = MBOX_EN && !r_ce_ni && !r_oe_ni && (r_addr_i == RMb);

  always_comb begin
    if (!rst_ni) begin
      a_r1_reset_idle: assert (l_int_no && r_int_no);
    end
  end

  a_r3_set_left: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_l |=> !l_int_no);
  a_r4_set_right: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_r |=> !r_int_no);
  a_r5_clr_left: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_l && !set_l) |=> l_int_no);
  a_r6_clr_right: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_r && !set_r) |=> r_int_no);
  a_r8_hold_left: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!set_l && !clr_l) |=> $stable(l_int_no));
  a_r8_hold_right: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!set_r && !clr_r) |=> $stable(r_int_no));
  a_r9_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !MBOX_EN |-> (l_int_no && r_int_no));
endmodule

bind dpm_mailbox_irq dpm_mailbox_chk #(.ADDR_W(ADDR_W), .MBOX_EN(MBOX_EN)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni),
  .l_ce_ni(l_ce_ni), .l_we_ni(l_we_ni), .l_oe_ni(l_oe_ni), .l_addr_i(l_addr_i),
  .l_int_no(l_int_no),
  .r_ce_ni(r_ce_ni), .r_we_ni(r_we_ni), .r_oe_ni(r_oe_ni), .r_addr_i(r_addr_i),
  .r_int_no(r_int_no)
);

// File: tb/tb_dpm_mailbox_irq.sv
module tb_dpm_mailbox_irq;
  localparam int unsigned AW = 10;
  localparam int unsigned DW = 8;
  localparam logic [AW-1:0] LMB = AW'((1 << AW) - 2);
  localparam logic [AW-1:0] RMB = AW'((1 << AW) - 1);

  // scoreboard selectors
  localparam int S_LRD = 0, S_RRD = 1, S_LINT = 2, S_RINT = 3;
  localparam int S_OLINT = 4, S_ORINT = 5, S_OLRD = 6;

  typedef struct {
    int        due;
    int        sel;
    logic [7:0] exp;
    string     req;
  } item_t;

  logic clk = 1'b0, rst_n = 1'b0;
  logic l_ce, l_we, l_oe, r_ce, r_we, r_oe;
  logic [AW-1:0] l_addr, r_addr;
  logic [DW-1:0] l_wd, r_wd;
  logic [DW-1:0] l_rd, r_rd, o_l_rd, o_r_rd;
  logic l_int, r_int, o_l_int, o_r_int;

  int checks = 0, failures = 0, cyc = 0;
  bit done = 1'b0;
  item_t sbq[$];

  always #4 clk = ~clk;

  dpm_mailbox_irq #(.ADDR_W(AW), .DATA_W(DW), .MBOX_EN(1'b1)) dut (
    .clk_i(clk), .rst_ni(rst_n),
    .l_ce_ni(l_ce), .l_we_ni(l_we), .l_oe_ni(l_oe), .l_addr_i(l_addr),
    .l_wdata_i(l_wd), .l_rdata_o(l_rd), .l_int_no(l_int),
    .r_ce_ni(r_ce), .r_we_ni(r_we), .r_oe_ni(r_oe), .r_addr_i(r_addr),
    .r_wdata_i(r_wd), .r_rdata_o(r_rd), .r_int_no(r_int)
  );

  dpm_mailbox_irq #(.ADDR_W(AW), .DATA_W(DW), .MBOX_EN(1'b0)) dut_off (
    .clk_i(clk), .rst_ni(rst_n),
    .l_ce_ni(l_ce), .l_we_ni(l_we), .l_oe_ni(l_oe), .l_addr_i(l_addr),
    .l_wdata_i(l_wd), .l_rdata_o(o_l_rd), .l_int_no(o_l_int),
    .r_ce_ni(r_ce), .r_we_ni(r_we), .r_oe_ni(r_oe), .r_addr_i(r_addr),
    .r_wdata_i(r_wd), .r_rdata_o(o_r_rd), .r_int_no(o_r_int)
  );

  function automatic logic [7:0] pick(int sel);
    case (sel)
      S_LRD:   return l_rd;
      S_RRD:   return r_rd;
      S_LINT:  return {7'd0, l_int};
      S_RINT:  return {7'd0, r_int};
      S_OLINT: return {7'd0, o_l_int};
      S_ORINT: return {7'd0, o_r_int};
      default: return o_l_rd;
    endcase
  endfunction

  task automatic judge(int sel, logic [7:0] exp, string req);
    logic [7:0] act;
    act = pick(sel);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s sel=%0d actual=%h expected=%h", req, sel, act, exp);
    end
  endtask

  // monitor: pop items due at this edge
  always @(posedge clk) begin
    cyc++;
    #1;
    while (sbq.size() > 0 && sbq[0].due <= cyc) begin
      item_t it;
      it = sbq.pop_front();
      judge(it.sel, it.exp, it.req);
    end
  end

  task automatic expect_nx(int sel, logic [7:0] exp, string req);
    item_t it;
    it.due = cyc + 1; it.sel = sel; it.exp = exp; it.req = req;
    sbq.push_back(it);
  endtask

  // drive one cycle of both ports at the falling edge
  task automatic step(logic lce, logic lwe, logic loe, logic [AW-1:0] la, logic [7:0] lw,
                      logic rce, logic rwe, logic roe, logic [AW-1:0] ra, logic [7:0] rw);
    @(negedge clk);
    l_ce = lce; l_we = lwe; l_oe = loe; l_addr = la; l_wd = lw;
    r_ce = rce; r_we = rwe; r_oe = roe; r_addr = ra; r_wd = rw;
  endtask

  localparam logic I = 1'b1;  // inactive level

  initial begin
    l_ce = I; l_we = I; l_oe = I; l_addr = '0; l_wd = '0;
    r_ce = I; r_we = I; r_oe = I; r_addr = '0; r_wd = '0;
    repeat (3) @(posedge clk);
    #1;
    judge(S_LINT, 8'd1, "R1 l_int reset");
    judge(S_RINT, 8'd1, "R1 r_int reset");
    judge(S_LRD, 8'h00, "R1 l_rdata reset");
    judge(S_RRD, 8'h00, "R1 r_rdata reset");
    @(negedge clk); rst_n = 1'b1;

    // R2 basic storage
    step(0,0,I,10'h010,8'hA5, I,I,I,10'h000,8'h00);
    step(0,I,0,10'h010,8'h00, 0,0,I,10'h020,8'h3C);
    expect_nx(S_LRD, 8'hA5, "R2 left read");
    step(0,I,0,10'h020,8'h00, 0,I,0,10'h020,8'h00);
    expect_nx(S_LRD, 8'h3C, "R2 left read of right data");
    expect_nx(S_RRD, 8'h3C, "R2 right read");
    expect_nx(S_LINT, 8'd1, "R8 plain traffic no irq");

    // R3 set left irq
    step(I,I,I,10'h000,8'h00, 0,0,I,LMB,8'h77);
    expect_nx(S_LINT, 8'd0, "R3 left irq set");
    expect_nx(S_OLINT, 8'd1, "R9 disabled no left irq");
    step(I,I,I,10'h000,8'h00, I,I,I,10'h000,8'h00);
    expect_nx(S_LINT, 8'd0, "R3 left irq held");

    // R5 clear by reading
    step(0,I,0,LMB,8'h00, I,I,I,10'h000,8'h00);
    expect_nx(S_LINT, 8'd1, "R5 left irq cleared");
    expect_nx(S_LRD, 8'h77, "R10 left mailbox message");
    expect_nx(S_OLRD, 8'h77, "R9 disabled top location stores");

    // R4 set right irq
    step(0,0,I,RMB,8'h99, I,I,I,10'h000,8'h00);
    expect_nx(S_RINT, 8'd0, "R4 right irq set");
    expect_nx(S_ORINT, 8'd1, "R9 disabled no right irq");

    // R8 own mailbox write
    step(0,0,I,LMB,8'h11, I,I,I,10'h000,8'h00);
    expect_nx(S_LINT, 8'd1, "R8 own write no irq");
    expect_nx(S_RINT, 8'd0, "R4 right irq held");

    // R8 read with chip enable high
    step(I,I,I,10'h000,8'h00, I,I,0,RMB,8'h00);
    expect_nx(S_RINT, 8'd0, "R8 deselected read no clear");

    // R6 right clear
    step(I,I,I,10'h000,8'h00, 0,I,0,RMB,8'h00);
    expect_nx(S_RINT, 8'd1, "R6 right irq cleared");
    expect_nx(S_RRD, 8'h99, "R10 right mailbox message");

    // R7 set vs clear on left
    step(I,I,I,10'h000,8'h00, 0,0,I,LMB,8'h55);
    expect_nx(S_LINT, 8'd0, "R3 left irq set again");
    step(0,I,0,LMB,8'h00, 0,0,I,LMB,8'h66);
    expect_nx(S_LINT, 8'd0, "R7 left set wins");
    expect_nx(S_LRD, 8'h55, "R2 read-during-write old byte");

    // R5 clear with write strobe low
    step(0,0,0,LMB,8'h66, I,I,I,10'h000,8'h00);
    expect_nx(S_LINT, 8'd1, "R5 clear ignores write strobe");
    step(0,I,0,LMB,8'h00, I,I,I,10'h000,8'h00);
    expect_nx(S_LRD, 8'h66, "R10 reread unchanged");
    expect_nx(S_LINT, 8'd1, "R5 stays cleared");

    // R7 set vs clear on right
    step(0,0,I,RMB,8'h42, 0,I,0,RMB,8'h00);
    expect_nx(S_RINT, 8'd0, "R7 right set wins");
    expect_nx(S_ORINT, 8'd1, "R9 disabled right quiet");

    step(I,I,I,10'h000,8'h00, I,I,I,10'h000,8'h00);
    repeat (3) @(posedge clk);
    #2;
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        checks++; failures++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule